// File: doc/BRIEF.md
# Program-Partitioned Multi-Tap Delay Engine

This block is a digital audio delay core that runs at the sample rate. One shared sample memory is split into one to four circular delay channels. A four-bit program number chooses the split. Each channel takes its input sample on every sample strobe. Four read taps return delayed copies of the channel inputs. Each tap has its own control word, and that word places the tap's delay inside a window. Two global controls set the window, and the channel's region size bounds it.

On each accepted strobe the engine works through a fixed schedule. It reads the four taps one after another, then writes each active channel once, then presents all four tap outputs together with a one-cycle valid pulse. When the program number changes, the engine sweeps the whole memory to zero before it accepts new samples. A program number outside the supported range is flagged, and strobes are then ignored.

Top module: `tapdelay_core`

## Requirements
- R1: Program 0 forms one channel with the full memory (2048 samples by default). All four taps read the channel fed by input 0.
- R2: Program 1 forms two channels of half the memory each. Taps 0 and 1 read channel 0, which is fed by input 0. Taps 2 and 3 read channel 1, which is fed by input 1.
- R3: Program 2 forms three channels of floor(depth/3) samples each. Tap 0 reads channel 0, tap 1 reads channel 1, and taps 2 and 3 read channel 2. Channel c is fed by input c.
- R4: Program 3 forms four channels of a quarter of the memory each. Tap c reads channel c, which is fed by input c.
- R5: The delay in samples is d = lo + (hi − lo)·ctl / 255, using integer division with floor. Here lo = 14 + S·min(a,b)/255 and hi = 14 + S·max(a,b)/255, where S = region − 1 − 14. The output at strobe n is the channel's input at strobe n − d.
- R6: The two window controls form an unordered pair: swapping them leaves every delay unchanged. When they are equal, every tap gets the same delay whatever its control word.
- R7: The delay never falls below 14 samples and never exceeds region − 1.
- R8: A tap's output depends only on its own control word. Changing another tap's control word has no effect on it.
- R9: After reset or any change of program number, the memory is cleared. Until a tap's delay has been covered by new strobes, that tap reads zero.
- R10: A program number of 4 or above raises prog_bad_o. While it is raised, strobes produce no valid pulse and the outputs stay at zero.
- R11: Each channel's write position wraps inside its own region. Delays stay correct after more strobes than the region holds.
- R12: Each accepted strobe gives exactly one single-cycle tap_valid_o pulse. A strobe that arrives while a previous one is still being processed is dropped. Reset leaves the outputs at zero with no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| prog_i | input | 4 | Program number |
| strobe_i | input | 1 | Sample strobe; accepted only when the engine is idle |
| sample_i | input | 4×DW | One input sample per channel input |
| tap_ctl_i | input | 4×CW | Delay control word for each tap |
| win_a_i | input | CW | First window control |
| win_b_i | input | CW | Second window control |
| tap_o | output | 4×DW | Tap outputs, held between valid pulses |
| tap_valid_o | output | 1 | One-cycle pulse when new tap outputs are ready |
| prog_bad_o | output | 1 | Program number is outside the supported set |

## Verification
The bench runs each program for more strobes than its region holds, so every write pointer wraps at least once. A design with the wrong wrap point or the wrong region base would return samples from another channel, or from stale positions, after the first wrap. Control words include the extremes 0 and 255, swapped and equal window pairs, and one phase that moves only tap 0. These would expose an off-by-one in the scaling, a window that trusts input order, or crosstalk between taps. A program switch after a filled buffer, a jump to an unsupported program, and a doubled strobe check that stale samples read zero, that a bad program stays silent, and that a strobe arriving while busy gives no second pulse.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int NUM_CH = 4;

    typedef enum logic [2:0] {
        ST_CLEAR   = 3'd0,
        ST_IDLE    = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_PUBLISH = 3'd4
    } state_e;

    // channel that a tap reads under a given supported program
    function automatic logic [1:0] tap_channel(input logic [1:0] prog, input logic [1:0] tap);
        case (prog)
            2'd0:    return 2'd0;
            2'd1:    return {1'b0, tap[1]};
            2'd2:    return (tap == 2'd3) ? 2'd2 : tap;
            default: return tap;
        endcase
    endfunction

endpackage

// File: rtl/tdc_layout.sv
module tdc_layout #(
    parameter int AW = 11
) (
    input  logic [3:0]  prog_i,
    output logic        ok_o,
    output logic [AW:0] region_o,
    output logic [2:0]  nchan_o
);
    localparam int DEPTH = 2 ** AW;
    localparam logic [AW:0] SZ_ONE   = (AW+1)'(DEPTH);
    localparam logic [AW:0] SZ_TWO   = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] SZ_THREE = (AW+1)'(DEPTH / 3);
    localparam logic [AW:0] SZ_FOUR  = (AW+1)'(DEPTH / 4);

    always_comb begin
        ok_o    = (prog_i < 4'd4);
        nchan_o = {1'b0, prog_i[1:0]} + 3'd1;
        case (prog_i[1:0])
            2'd0:    region_o = SZ_ONE;
            2'd1:    region_o = SZ_TWO;
            2'd2:    region_o = SZ_THREE;
            default: region_o = SZ_FOUR;
        endcase
    end
endmodule

// File: rtl/tdc_tap_delay.sv
module tdc_tap_delay #(
    parameter int AW      = 11,
    parameter int CW      = 8,
    parameter int MIN_DLY = 14
) (
    input  logic [AW:0]   region_i,
    input  logic [CW-1:0] win_a_i,
    input  logic [CW-1:0] win_b_i,
    input  logic [CW-1:0] ctl_i,
    output logic [AW:0]   win_lo_o,
    output logic [AW:0]   win_hi_o,
    output logic [AW:0]   delay_o
);
    localparam int PW = AW + 1 + CW;
    localparam int FS = 2 ** CW - 1;
    localparam logic [AW:0] MIN_L = (AW+1)'(MIN_DLY);

    logic [CW-1:0] lo, hi;
    logic [AW:0]   top, span, raw;

    always_comb begin
        lo       = (win_a_i < win_b_i) ? win_a_i : win_b_i;
        hi       = (win_a_i < win_b_i) ? win_b_i : win_a_i;
        top      = region_i - 1'b1;
        span     = (top > MIN_L) ? (top - MIN_L) : '0;
        win_lo_o = MIN_L + (AW+1)'((PW'(span) * PW'(lo)) / PW'(FS));
        win_hi_o = MIN_L + (AW+1)'((PW'(span) * PW'(hi)) / PW'(FS));
        raw      = win_lo_o + (AW+1)'((PW'(win_hi_o - win_lo_o) * PW'(ctl_i)) / PW'(FS));
        delay_o  = (raw > top) ? top : raw;
    end
endmodule

// File: rtl/tdc_sample_ram.sv
module tdc_sample_ram #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/tapdelay_core.sv
module tapdelay_core
    import tdc_pkg::*;
#(
    parameter int AW      = 11,
    parameter int DW      = 16,
    parameter int CW      = 8,
    parameter int MIN_DLY = 14
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [3:0]               prog_i,
    input  logic                     strobe_i,
    input  logic [NUM_CH-1:0][DW-1:0] sample_i,
    input  logic [NUM_CH-1:0][CW-1:0] tap_ctl_i,
    input  logic [CW-1:0]            win_a_i,
    input  logic [CW-1:0]            win_b_i,
    output logic [NUM_CH-1:0][DW-1:0] tap_o,
    output logic                     tap_valid_o,
    output logic                     prog_bad_o
);
    typedef struct packed {
        state_e                    st;
        logic [3:0]                prog;
        logic [AW-1:0]             clr;
        logic [1:0]                idx;
        logic                      pend;
        logic [1:0]                pidx;
        logic [NUM_CH-1:0][AW:0]   wp;
        logic [NUM_CH-1:0][DW-1:0] smp;
        logic [NUM_CH-1:0][DW-1:0] acc;
        logic [NUM_CH-1:0][DW-1:0] out;
        logic                      vld;
    } core_t;

    core_t q, d;

    logic          prog_ok;
    logic [AW:0]   size;
    logic [2:0]    nchan;
    logic [1:0]    rch;
    logic [AW:0]   dly, win_lo, win_hi, rel, rbase, wbase, wpr, wnext;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] wdata, rdata;

    tdc_layout #(.AW(AW)) i_layout (
        .prog_i   (q.prog),
        .ok_o     (prog_ok),
        .region_o (size),
        .nchan_o  (nchan)
    );

    tdc_tap_delay #(.AW(AW), .CW(CW), .MIN_DLY(MIN_DLY)) i_delay (
        .region_i (size),
        .win_a_i  (win_a_i),
        .win_b_i  (win_b_i),
        .ctl_i    (tap_ctl_i[q.idx]),
        .win_lo_o (win_lo),
        .win_hi_o (win_hi),
        .delay_o  (dly)
    );

    tdc_sample_ram #(.AW(AW), .DW(DW)) i_ram (
        .clk_i   (clk_i),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    // read address of the tap being served
    always_comb begin
        rch   = tap_channel(q.prog[1:0], q.idx);
        wpr   = q.wp[rch];
        rel   = (wpr >= dly) ? (wpr - dly) : (wpr + size - dly);
        rbase = size * {{(AW-1){1'b0}}, rch};
        raddr = AW'(rbase + rel);
        wbase = size * {{(AW-1){1'b0}}, q.idx};
        wnext = q.wp[q.idx] + 1'b1;
    end

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.pend = 1'b0;
        we    = 1'b0;
        waddr = '0;
        wdata = '0;
        if (q.pend) d.acc[q.pidx] = rdata;
        case (q.st)
            ST_CLEAR: begin
                we    = 1'b1;
                waddr = q.clr;
                d.clr = q.clr + 1'b1;
                if (&q.clr) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (prog_i != q.prog) begin
                    d.st   = ST_CLEAR;
                    d.prog = prog_i;
                    d.clr  = '0;
                    d.wp   = '0;
                    d.out  = '0;
                end else if (strobe_i && prog_ok) begin
                    d.smp = sample_i;
                    d.idx = 2'd0;
                    d.st  = ST_READ;
                end
            end
            ST_READ: begin
                d.pend = 1'b1;
                d.pidx = q.idx;
                d.idx  = q.idx + 1'b1;
                if (q.idx == 2'd3) d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if ({1'b0, q.idx} < nchan) begin
                    we    = 1'b1;
                    waddr = AW'(wbase + q.wp[q.idx]);
                    wdata = q.smp[q.idx];
                    d.wp[q.idx] = (wnext == size) ? '0 : wnext;
                end
                d.idx = q.idx + 1'b1;
                if (q.idx == 2'd3) d.st = ST_PUBLISH;
            end
            ST_PUBLISH: begin
                d.out = q.acc;
                d.vld = 1'b1;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tap_o       = q.out;
    assign tap_valid_o = q.vld;
    assign prog_bad_o  = !prog_ok;

    AST_DELAY_LIMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_READ) |-> (dly >= (AW+1)'(MIN_DLY) && dly < size)); // R7
    AST_DELAY_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_READ) |-> (dly >= win_lo && dly <= win_hi)); // R5
    AST_WINDOW_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_lo <= win_hi); // R6
    AST_READ_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_READ) |-> ((AW+1)'(raddr) >= rbase && (AW+1)'(raddr) < rbase + size)); // R11
    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_valid_o |=> !tap_valid_o); // R12
    AST_BAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_bad_o |-> !tap_valid_o); // R10

    for (genvar c = 0; c < NUM_CH; c++) begin : g_wp_chk
        AST_WP_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (prog_ok && c < int'(nchan)) |-> (q.wp[c] < size)); // R11
    end
endmodule

// File: tb/test_tapdelay_core.sv
module test_tapdelay_core;
    localparam int DEPTH = 2048;

    logic             clk_i = 1'b0;
    logic             rst_ni;
    logic [3:0]       prog_i;
    logic             strobe_i;
    logic [3:0][15:0] sample_i;
    logic [3:0][7:0]  tap_ctl_i;
    logic [7:0]       win_a_i, win_b_i;
    logic [3:0][15:0] tap_o;
    logic             tap_valid_o;
    logic             prog_bad_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk_i = ~clk_i;

    tapdelay_core i_tapdelay_core (
        .clk_i, .rst_ni, .prog_i, .strobe_i, .sample_i, .tap_ctl_i,
        .win_a_i, .win_b_i, .tap_o, .tap_valid_o, .prog_bad_o
    );

    function automatic logic [15:0] gen(int c, int n);
        return 16'((n * 97 + c * 4099 + 11) ^ (n << 5));
    endfunction

    function automatic int region_of(int p);
        return DEPTH / (p + 1);
    endfunction

    function automatic int chan_of(int p, int t);
        if (p == 0) return 0;
        if (p == 1) return t / 2;
        if (p == 2) return (t == 3) ? 2 : t;
        return t;
    endfunction

    function automatic int exp_delay(int region, int a, int b, int c);
        int lo   = (a < b) ? a : b;
        int hi   = (a < b) ? b : a;
        int top  = region - 1;
        int span = top - 14;
        int wlo  = 14 + span * lo / 255;
        int whi  = 14 + span * hi / 255;
        int dd   = wlo + (whi - wlo) * c / 255;
        if (dd > top) dd = top;
        return dd;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_clear();
        repeat (DEPTH + 60) @(negedge clk_i);
    endtask

    // one strobe: n is the strobe index since the program took effect
    task automatic do_strobe(int p, int n, string ptag, string ph, bit dbl);
        int w = 0;
        int extra = 0;
        for (int c = 0; c < 4; c++) sample_i[c] = gen(c, n);
        strobe_i = 1'b1;
        @(negedge clk_i);
        if (dbl) @(negedge clk_i);
        strobe_i = 1'b0;
        while (!tap_valid_o && w < 40) begin
            @(negedge clk_i);
            w++;
        end
        check(tap_valid_o, {ptag, " R12 valid pulse"}, int'(tap_valid_o), 1);
        for (int t = 0; t < 4; t++) begin
            int dd = exp_delay(region_of(p), win_a_i, win_b_i, tap_ctl_i[t]);
            int ch = chan_of(p, t);
            logic [15:0] ev = (n >= dd) ? gen(ch, n - dd) : 16'h0;
            string tg = (n < dd) ? "R9 zero history" : (n >= region_of(p)) ? "R11 wrapped" : ph;
            check(tap_o[t] == ev, $sformatf("%s %s tap%0d n=%0d", ptag, tg, t, n),
                  int'($signed(tap_o[t])), int'($signed(ev)));
        end
        @(negedge clk_i);
        check(!tap_valid_o, {ptag, " R12 single cycle"}, int'(tap_valid_o), 0);
        if (dbl) begin
            for (int k = 0; k < 20; k++) begin
                if (tap_valid_o) extra++;
                @(negedge clk_i);
            end
            check(extra == 0, {ptag, " R12 busy strobe dropped"}, extra, 0);
        end
    endtask

    task automatic run_prog(int p, int a, int b, int count, string ptag);
        prog_i  = 4'(p);
        win_a_i = 8'(a);
        win_b_i = 8'(b);
        wait_clear();
        for (int n = 0; n < count; n++) begin
            int k = n / 64;
            string ph;
            case (k % 4)
                0: begin
                    for (int t = 0; t < 4; t++) tap_ctl_i[t] = (t % 2 == 1) ? 8'd255 : 8'd0;
                    ph = "R7 extremes";
                end
                1: begin
                    for (int t = 0; t < 4; t++) tap_ctl_i[t] = 8'((k * 53 + t * 71) % 256);
                    ph = "R5 sweep";
                end
                2: begin
                    tap_ctl_i[0] = 8'((n * 7) % 256);
                    for (int t = 1; t < 4; t++) tap_ctl_i[t] = 8'd100;
                    ph = "R8 one tap moves";
                end
                default: begin
                    for (int t = 0; t < 4; t++) tap_ctl_i[t] = 8'((k * 29 + t * 113) % 256);
                    ph = "R6 window pair";
                end
            endcase
            do_strobe(p, n, ptag, ph, (n == 5));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int extra = 0;
        rst_ni    = 1'b0;
        prog_i    = 4'd0;
        strobe_i  = 1'b0;
        sample_i  = '0;
        tap_ctl_i = '0;
        win_a_i   = 8'd0;
        win_b_i   = 8'd255;
        repeat (5) @(negedge clk_i);
        check(tap_o == '0, "R12 reset outputs", int'(tap_o[0]), 0);
        check(!tap_valid_o, "R12 reset valid", int'(tap_valid_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(!prog_bad_o, "R10 reset flag", int'(prog_bad_o), 0);

        run_prog(0, 40, 200, region_of(0) + 60, "R1");
        run_prog(1, 200, 40, region_of(1) + 60, "R2");
        run_prog(2, 120, 120, region_of(2) + 60, "R3 R6");
        run_prog(3, 255, 0, region_of(3) + 60, "R4");

        // unsupported program
        prog_i = 4'd9;
        wait_clear();
        check(prog_bad_o, "R10 flag raised", int'(prog_bad_o), 1);
        check(tap_o == '0, "R10 outputs cleared", int'(tap_o[0]), 0);
        strobe_i = 1'b1;
        @(negedge clk_i);
        strobe_i = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (tap_valid_o) extra++;
            @(negedge clk_i);
        end
        check(extra == 0, "R10 strobe ignored", extra, 0);
        check(tap_o == '0, "R10 outputs stay zero", int'(tap_o[3]), 0);

        // back to a valid program after data was stored: history must read zero
        prog_i = 4'd1;
        win_a_i = 8'd255;
        win_b_i = 8'd255;
        wait_clear();
        check(!prog_bad_o, "R10 flag cleared", int'(prog_bad_o), 0);
        for (int n = 0; n < 40; n++) begin
            for (int t = 0; t < 4; t++) tap_ctl_i[t] = 8'(t * 80);
            do_strobe(1, n, "R9 after switch", "R6 equal window", 1'b0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule